// File: doc/BRIEF.md
# Dual-Rail Serial Word Transmitter

This block turns a 32-bit word, written by a host as four bytes, into a return-to-zero serial stream on two rails. One rail pulses for a 0 bit and the other pulses for a 1 bit. Each bit lasts four clocks: the selected rail is high for two clocks, then both rails are low for two clocks. The first byte written goes out first, and each byte is sent least significant bit first. After a word, and after reset, the line stays null for at least four bit times before the next word can start.

The block has two fill modes. In word mode the host stages all four bytes while the transmitter is idle, and the word then waits for the release conditions. In byte mode the first byte alone is enough to start. The host then writes each further byte on the fly while the previous one is being shifted out. If a byte arrives late, the word is abandoned and the transmitter stops until the host acknowledges the error.

A start needs a staged word (or the first byte in byte mode), the enable input high and the clear-to-send input low. Optional odd parity replaces the last bit. A self-test input moves the waveform from the external rails to a pair of loopback rails that feed a local receiver.

Top module: `dtx_word_tx`

## Requirements
- R1: While and right after reset, `tx_idle`=1, `tx_ready`=1, `underwrite`=0 and all four rail outputs are 0. The first word cannot begin until at least 16 clocks after reset is released.
- R2: Every bit lasts 4 clocks. Exactly one rail is high for the first 2 clocks (`*_zero` for a 0 bit, `*_one` for a 1 bit), then both rails are low for 2 clocks. The two rails are never high together.
- R3: A word is 32 bits. Byte k (k=0 is the first byte written) occupies word bits 8k..8k+7 and is sent bit 8k first. Only staged data is ever sent.
- R4: With `parity_en`=1, bit 32 (index 31) is sent as the complement of the XOR of bits 0..30, so the word carries an odd number of ones. With `parity_en`=0, bit 32 is the host's bit 7 of byte 3.
- R5: A word starts only when it is staged, `tx_enable`=1 and `cts_n`=0. A single-clock low pulse on `cts_n` releases exactly one word.
- R6: `tx_idle` is 0 from the first clock of bit 1 through the last clock of bit 32, and returns to 1 on the following clock.
- R7: Between consecutive words the rails stay null for at least 16 clocks (4 bit times).
- R8: `tx_ready`=1 means a write (`wr_en`) is accepted. In word mode, `tx_ready` is high while idle with fewer than 4 bytes staged. In byte mode, it is high when idle and empty, or while sending byte k when byte k+1 is not yet staged. A write with `tx_ready`=0 has no effect on the data sent.
- R9: In byte mode, if byte k+1 (k<3) is not staged before the last clock of byte k's eighth bit, `underwrite` becomes 1 after that bit, the word is abandoned, the rails go null and `tx_idle` returns to 1.
- R10: While `underwrite`=1, `tx_ready`=0, writes are ignored and no word starts. A one-clock `err_clr` pulse clears `underwrite` and makes `tx_ready`=1 again.
- R11: With `selftest`=1, `line_zero`/`line_one` stay 0 and the waveform appears on `loop_zero`/`loop_one`. With `selftest`=0, the loop rails stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, four times the bit rate |
| rst | input | 1 | Master reset, active high, asynchronous |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| fill_byte | input | 1 | 1 = byte mode (on-the-fly), 0 = word mode |
| tx_enable | input | 1 | Transmitter enable control bit |
| parity_en | input | 1 | 1 = bit 32 is generated odd parity |
| selftest | input | 1 | 1 = route waveform to loopback rails |
| cts_n | input | 1 | Clear-to-send gate, active low |
| err_clr | input | 1 | Status-read pulse that clears the underwrite error |
| tx_ready | output | 1 | Host may write the next byte |
| tx_idle | output | 1 | Low while a word is on the line |
| underwrite | output | 1 | Byte-mode underwrite error, transmitter halted |
| line_zero | output | 1 | External zero rail |
| line_one | output | 1 | External one rail |
| loop_zero | output | 1 | Loopback zero rail to local receiver |
| loop_one | output | 1 | Loopback one rail to local receiver |

## Verification
The hardest case to reach is an underwrite: a byte-mode word that has actually started and then runs dry exactly at a byte boundary. The halted state then has to be shown to swallow both writes and start attempts. The stimulus gets there by writing a single byte with clear-to-send held low, and expecting exactly eight bits on the line. While the error flag is up, the bench writes another byte and waits long enough that any start would show as an unexpected bit, and only then pulses the clear. Back-to-back words are loaded as soon as the line goes idle, so the gap is measured at its minimum rather than stretched by a slow host.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    // Clock phases per serial bit: the rail is high in the first PH_HIGH of them.
    localparam int PH_PER_BIT = 4;
    localparam int PH_W       = 2;
    localparam int PH_HIGH    = 2;

    typedef enum logic {
        FILL_WORD = 1'b0,
        FILL_BYTE = 1'b1
    } fill_mode_e;

endpackage

// File: rtl/dtx_buffer.sv
module dtx_buffer
    import dtx_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  fill_mode_e                        fill_mode,
    input  logic                              wr_en,
    input  logic [BYTE_W-1:0]                 wr_data,
    input  logic                              busy,
    input  logic                              halted,
    input  logic [$clog2(WORD_BYTES)-1:0]     cur_byte,
    input  logic                              drain,
    output logic [BYTE_W*WORD_BYTES-1:0]      word,
    output logic [$clog2(WORD_BYTES+1)-1:0]   count,
    output logic                              ready
);

    localparam int WORD_W = BYTE_W * WORD_BYTES;
    localparam int CNT_W  = $clog2(WORD_BYTES + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } stage_s;

    stage_s st_q, st_d;
    logic   ready_c;

    // Acceptance window for the next host byte.
    always_comb begin
        if (halted || st_q.cnt == CNT_W'(WORD_BYTES)) begin
            ready_c = 1'b0;
        end else if (fill_mode == FILL_BYTE) begin
            ready_c = busy ? (st_q.cnt == CNT_W'(cur_byte) + CNT_W'(1))
                           : (st_q.cnt == '0);
        end else begin
            ready_c = !busy;
        end
    end

    always_comb begin
        st_d = st_q;
        if (drain) begin
            st_d.cnt = '0;
        end else if (wr_en && ready_c) begin
            for (int k = 0; k < WORD_BYTES; k++) begin
                if (CNT_W'(k) == st_q.cnt) begin
                    st_d.word[k*BYTE_W +: BYTE_W] = wr_data;
                end
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word  = st_q.word;
    assign count = st_q.cnt;
    assign ready = ready_c;

    assert_ignored_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ready && !drain) |=> ($stable(st_q.cnt) && $stable(st_q.word)));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_W'(WORD_BYTES));

endmodule

// File: rtl/dtx_sequencer.sv
module dtx_sequencer
    import dtx_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int GAP_BITS   = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  fill_mode_e                        fill_mode,
    input  logic                              enable,
    input  logic                              parity_en,
    input  logic                              cts_n,
    input  logic                              err_clr,
    input  logic [BYTE_W*WORD_BYTES-1:0]      word,
    input  logic [$clog2(WORD_BYTES+1)-1:0]   count,
    output logic                              busy,
    output logic                              halted,
    output logic [$clog2(WORD_BYTES)-1:0]     cur_byte,
    output logic                              drain,
    output logic                              bit_val,
    output logic [PH_W-1:0]                   phase
);

    localparam int WORD_W   = BYTE_W * WORD_BYTES;
    localparam int BIT_W    = $clog2(WORD_W);
    localparam int LOW_W    = $clog2(BYTE_W);
    localparam int CNT_W    = $clog2(WORD_BYTES + 1);
    localparam int GAP_CLKS = GAP_BITS * PH_PER_BIT;
    localparam int GAP_W    = $clog2(GAP_CLKS + 1);

    typedef struct packed {
        logic             busy;
        logic             halted;
        logic [BIT_W-1:0] bit_idx;
        logic [PH_W-1:0]  ph;
        logic [GAP_W-1:0] gap;
    } seq_s;

    seq_s sq_q, sq_d;

    logic loaded, gap_done, start, bit_end, word_end, starved;
    logic [$clog2(WORD_BYTES)-1:0] byte_now;

    assign byte_now = sq_q.bit_idx[BIT_W-1:LOW_W];

    always_comb begin
        loaded   = (fill_mode == FILL_BYTE) ? (count != '0)
                                            : (count == CNT_W'(WORD_BYTES));
        gap_done = (sq_q.gap == GAP_W'(GAP_CLKS));
        start    = !sq_q.busy && !sq_q.halted && gap_done && loaded
                   && enable && !cts_n;
        bit_end  = sq_q.busy && (sq_q.ph == PH_W'(PH_PER_BIT - 1));
        word_end = bit_end && (sq_q.bit_idx == BIT_W'(WORD_W - 1));
        // Last bit of a byte leaves with the following byte still missing.
        starved  = (fill_mode == FILL_BYTE) && bit_end && !word_end
                   && (sq_q.bit_idx[LOW_W-1:0] == {LOW_W{1'b1}})
                   && (count <= CNT_W'(byte_now) + CNT_W'(1));

        sq_d = sq_q;
        if (err_clr) sq_d.halted = 1'b0;

        if (start) begin
            sq_d.busy    = 1'b1;
            sq_d.bit_idx = '0;
            sq_d.ph      = '0;
        end else if (sq_q.busy) begin
            sq_d.ph = sq_q.ph + PH_W'(1);
            if (bit_end) begin
                sq_d.ph = '0;
                if (word_end || starved) begin
                    sq_d.busy = 1'b0;
                    sq_d.gap  = '0;
                    if (starved) sq_d.halted = 1'b1;
                end else begin
                    sq_d.bit_idx = sq_q.bit_idx + BIT_W'(1);
                end
            end
        end else if (!gap_done) begin
            sq_d.gap = sq_q.gap + GAP_W'(1);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) sq_q <= '0;
        else     sq_q <= sq_d;
    end

    always_comb begin
        if (parity_en && sq_q.bit_idx == BIT_W'(WORD_W - 1))
            bit_val = ~(^word[WORD_W-2:0]);
        else
            bit_val = word[sq_q.bit_idx];
    end

    assign busy     = sq_q.busy;
    assign halted   = sq_q.halted;
    assign cur_byte = byte_now;
    assign drain    = word_end || starved;
    assign phase    = sq_q.ph;

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (sq_q.busy && sq_q.ph != PH_W'(PH_PER_BIT - 1))
        |=> (sq_q.busy && sq_q.ph == $past(sq_q.ph) + PH_W'(1)));

    assert_start_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (!sq_q.busy && !(enable && !cts_n)) |=> !sq_q.busy);

    assert_halt_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        sq_q.halted |=> !sq_q.busy);

    assert_gap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!sq_q.busy && sq_q.gap < GAP_W'(GAP_CLKS)) |=> !sq_q.busy);

endmodule

// File: rtl/dtx_linemux.sv
module dtx_linemux
    import dtx_pkg::*;
(
    input  logic            busy,
    input  logic [PH_W-1:0] phase,
    input  logic            bit_val,
    input  logic            selftest,
    output logic            line_zero,
    output logic            line_one,
    output logic            loop_zero,
    output logic            loop_one
);

    logic rz_on, rail_z, rail_o;

    always_comb begin
        rz_on  = busy && (phase < PH_W'(PH_HIGH));
        rail_z = rz_on && !bit_val;
        rail_o = rz_on && bit_val;
        line_zero = selftest ? 1'b0   : rail_z;
        line_one  = selftest ? 1'b0   : rail_o;
        loop_zero = selftest ? rail_z : 1'b0;
        loop_one  = selftest ? rail_o : 1'b0;
    end

endmodule

// File: rtl/dtx_word_tx.sv
module dtx_word_tx
    import dtx_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int GAP_BITS   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              fill_byte,
    input  logic              tx_enable,
    input  logic              parity_en,
    input  logic              selftest,
    input  logic              cts_n,
    input  logic              err_clr,
    output logic              tx_ready,
    output logic              tx_idle,
    output logic              underwrite,
    output logic              line_zero,
    output logic              line_one,
    output logic              loop_zero,
    output logic              loop_one
);

    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int CNT_W      = $clog2(WORD_BYTES + 1);
    localparam int BYTE_IDX_W = $clog2(WORD_BYTES);

    fill_mode_e              mode;
    logic [WORD_W-1:0]       word;
    logic [CNT_W-1:0]        count;
    logic [BYTE_IDX_W-1:0]   cur_byte;
    logic                    busy, halted, drain, bit_val, ready;
    logic [PH_W-1:0]         phase;

    assign mode = fill_mode_e'(fill_byte);

    dtx_buffer #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_buffer (
        .clk(clk), .rst(rst), .fill_mode(mode), .wr_en(wr_en), .wr_data(wr_data),
        .busy(busy), .halted(halted), .cur_byte(cur_byte), .drain(drain),
        .word(word), .count(count), .ready(ready)
    );

    dtx_sequencer #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .GAP_BITS(GAP_BITS)) u_seq (
        .clk(clk), .rst(rst), .fill_mode(mode), .enable(tx_enable),
        .parity_en(parity_en), .cts_n(cts_n), .err_clr(err_clr),
        .word(word), .count(count), .busy(busy), .halted(halted),
        .cur_byte(cur_byte), .drain(drain), .bit_val(bit_val), .phase(phase)
    );

    dtx_linemux u_mux (
        .busy(busy), .phase(phase), .bit_val(bit_val), .selftest(selftest),
        .line_zero(line_zero), .line_one(line_one),
        .loop_zero(loop_zero), .loop_one(loop_one)
    );

    assign tx_ready   = ready;
    assign tx_idle    = !busy;
    assign underwrite = halted;

    assert_rails_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(line_zero && line_one) && !(loop_zero && loop_one));

    assert_selftest_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        selftest |-> (!line_zero && !line_one));

    assert_halt_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
        underwrite |-> !tx_ready);

endmodule

// File: tb/tb_dtx_word_tx.sv
module tb_dtx_word_tx;

    localparam int CLK_PERIOD = 10;
    localparam int GAP_CLKS   = 16;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        logic v;
        bit   first;
        bit   last;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fill_byte = 1'b0, tx_enable = 1'b1, parity_en = 1'b0;
    logic       selftest = 1'b0, cts_n = 1'b1, err_clr = 1'b0;
    logic       tx_ready, tx_idle, underwrite;
    logic       line_zero, line_one, loop_zero, loop_one;

    exp_t exp_q[$];
    int   checks = 0, errors = 0;
    bit   st_mode = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtx_word_tx dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .fill_byte(fill_byte), .tx_enable(tx_enable), .parity_en(parity_en),
        .selftest(selftest), .cts_n(cts_n), .err_clr(err_clr),
        .tx_ready(tx_ready), .tx_idle(tx_idle), .underwrite(underwrite),
        .line_zero(line_zero), .line_one(line_one),
        .loop_zero(loop_zero), .loop_one(loop_one)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver side: expected bits for the scoreboard.
    task automatic push_word(input logic [31:0] w, input bit par);
        for (int i = 0; i < 32; i++) begin
            exp_t e;
            e.v     = (i == 31 && par) ? ~(^w[30:0]) : w[i];
            e.first = (i == 0);
            e.last  = (i == 31);
            exp_q.push_back(e);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_word(input logic [31:0] w);
        for (int k = 0; k < 4; k++) write_byte(w[8*k +: 8]);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (exp_q.size() != 0 || !tx_idle) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: decode the rails and compare with the scoreboard queue.
    bit   in_bit = 0, rail = 0, last_seen = 0, idle_chk = 0;
    int   hi_run = 0, lo_run = 0;

    always @(negedge clk) begin
        logic z, o;
        exp_t e;
        if (rst) begin
            in_bit = 0; hi_run = 0; lo_run = 0; last_seen = 0; idle_chk = 0;
        end else begin
            z = line_zero | loop_zero;
            o = line_one  | loop_one;
            if (z || o) begin
                if (!in_bit) begin
                    in_bit = 1; hi_run = 1; rail = o;
                    check(!(z && o), "R2 rails exclusive", {z, o}, 2'b01);
                    if (st_mode)
                        check(!line_zero && !line_one, "R11 external rails quiet in self-test",
                              {line_zero, line_one}, 0);
                    else
                        check(!loop_zero && !loop_one, "R11 loop rails quiet in normal mode",
                              {loop_zero, loop_one}, 0);
                    if (exp_q.size() == 0) begin
                        check(0, "R3 unexpected bit on line", o, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(o == e.v, "R3/R4 bit value", o, e.v);
                        if (e.first) begin
                            check(lo_run >= GAP_CLKS, "R7 null gap before word", lo_run, GAP_CLKS);
                            check(tx_idle == 1'b0, "R6 idle low at first bit", tx_idle, 0);
                        end else begin
                            check(lo_run == 2, "R2 low half length", lo_run, 2);
                        end
                        last_seen = e.last;
                    end
                    lo_run = 0;
                end else begin
                    hi_run++;
                    check(o == rail && z != o, "R2 rail steady in high half", o, rail);
                end
            end else begin
                if (in_bit) begin
                    in_bit = 0;
                    check(hi_run == 2, "R2 high half length", hi_run, 2);
                    lo_run = 1;
                end else if (lo_run < 1000000) begin
                    lo_run++;
                end
                if (idle_chk) begin
                    check(tx_idle == 1'b1, "R6 idle after final bit", tx_idle, 1);
                    idle_chk = 0;
                end else if (last_seen && lo_run == 2) begin
                    check(tx_idle == 1'b0, "R6 busy through final bit", tx_idle, 0);
                    idle_chk = 1; last_seen = 0;
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        check(tx_idle && tx_ready && !underwrite, "R1 reset outputs",
              {tx_idle, tx_ready, underwrite}, 3'b110);
        check(!line_zero && !line_one && !loop_zero && !loop_one, "R1 rails null in reset",
              {line_zero, line_one, loop_zero, loop_one}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_idle && tx_ready && !underwrite, "R1 outputs after reset",
              {tx_idle, tx_ready, underwrite}, 3'b110);

        // Word mode, data bit 32 (R3, R2, R6, R7 after reset).
        cts_n = 1'b0;
        push_word(32'hA5C3_0F81, 0);
        load_word(32'hA5C3_0F81);
        wait_done();

        // Parity, back-to-back words with minimum gap (R4, R7).
        parity_en = 1'b1;
        push_word(32'h0000_0003, 1);
        load_word(32'h0000_0003);
        wait_done();
        push_word(32'h8000_0007, 1);
        load_word(32'h8000_0007);
        wait_done();
        parity_en = 1'b0;

        // Clear-to-send and enable gating, ignored extra write (R5, R8).
        cts_n = 1'b1;
        push_word(32'h1234_5678, 0);
        load_word(32'h1234_5678);
        check(tx_ready == 1'b0, "R8 ready low with full word staged", tx_ready, 0);
        write_byte(8'hEE);
        repeat (60) @(negedge clk);
        check(tx_idle == 1'b1, "R5 held by cts_n high", tx_idle, 1);
        check(exp_q.size() == 32, "R5 nothing sent while gated", exp_q.size(), 32);
        tx_enable = 1'b0; cts_n = 1'b0;
        repeat (30) @(negedge clk);
        check(tx_idle == 1'b1, "R5 held by enable low", tx_idle, 1);
        cts_n = 1'b1; tx_enable = 1'b1;
        @(negedge clk); cts_n = 1'b0;
        @(negedge clk); cts_n = 1'b1;
        wait_done();
        push_word(32'h0BAD_F00D, 0);
        load_word(32'h0BAD_F00D);
        repeat (40) @(negedge clk);
        check(tx_idle == 1'b1, "R5 one word per cts pulse", tx_idle, 1);
        cts_n = 1'b0;
        wait_done();

        // Byte mode on the fly with parity (R8, R3, R4).
        fill_byte = 1'b1; parity_en = 1'b1;
        w = 32'h5A3C_96E1;
        push_word(w, 1);
        write_byte(w[7:0]);
        check(tx_ready == 1'b0, "R8 byte mode ready low before start", tx_ready, 0);
        for (int k = 1; k < 4; k++) begin
            do @(negedge clk); while (!tx_ready);
            write_byte(w[8*k +: 8]);
            check(tx_ready == 1'b0, "R8 byte mode one byte ahead", tx_ready, 0);
            if (k == 1) write_byte(8'h00);
        end
        wait_done();
        parity_en = 1'b0;

        // Underwrite: only the first byte arrives (R9, R10).
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            e.v = 8'h96 >> i; e.first = (i == 0); e.last = (i == 7);
            exp_q.push_back(e);
        end
        write_byte(8'h96);
        wait_done();
        check(underwrite == 1'b1, "R9 underwrite flagged", underwrite, 1);
        check(tx_idle == 1'b1, "R9 word abandoned", tx_idle, 1);
        check(tx_ready == 1'b0, "R10 not ready while halted", tx_ready, 0);
        write_byte(8'h55);
        repeat (40) @(negedge clk);
        check(tx_idle == 1'b1 && underwrite == 1'b1, "R10 stays halted",
              {tx_idle, underwrite}, 2'b11);
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check(underwrite == 1'b0 && tx_ready == 1'b1, "R10 cleared by status read",
              {underwrite, tx_ready}, 2'b01);
        fill_byte = 1'b0;

        // Self-test loopback (R11).
        selftest = 1'b1; st_mode = 1;
        push_word(32'hC0FF_EE11, 0);
        load_word(32'hC0FF_EE11);
        wait_done();
        selftest = 1'b0; st_mode = 0;

        check(exp_q.size() == 0, "R3 all expected bits seen", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule